// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Output Override

This block turns the event strobes of a PWM time-base counter into two output waveforms. Three strobes arrive from the counter: counter reached zero, counter matched compare A while counting up, and counter matched compare B while counting up. Each output channel has its own action register. For every event, that register says whether the channel's output level stays the same, goes low, goes high or toggles. Normal-polarity PWM sets the output at zero and clears it at the compare match. Inverted polarity does the opposite.

A separate override register can hold either output at a fixed low or high level for as long as it is programmed. It is used to park a disabled channel at its idle level: low for normal polarity, high for inverted. While an output is held, the channel's event-driven state keeps running. Clearing the override therefore returns the pin straight to the live waveform.

Configuration arrives through a simple write port: an address, a data word and a write enable. Channel A's action register is at address 0, channel B's at address 1, and the override register at address 2.

Top module: `aq_action_qual`

## Requirements
- R1: After reset both outputs are low and every action field is "no action", so no event changes either output until a channel is configured.
- R2: Each action register holds three 2-bit fields: the zero event at bits 1:0, compare-A-up at bits 5:4 and compare-B-up at bits 9:8. The code values are 0 = no action, 1 = drive low, 2 = drive high and 3 = toggle.
- R3: A strobe is sampled on a rising clock edge, and the resulting level shows on the output right after that same edge.
- R4: With zero = drive high and compare = drive low, the output is high for exactly as many counter ticks per period as the compare value. With the two actions swapped (inverted polarity), it is high for the period minus the compare value.
- R5: The override register (address 2) gives channel k the bits 2k+1:2k. Code 1 holds the output low, code 2 holds it high, and codes 0 and 3 release it. The change shows right after the clock edge that takes the write.
- R6: When several events are strobed in the same cycle, compare B has priority over compare A, and compare A has priority over zero. An event whose action is "no action" does not mask a lower-priority event.
- R7: While an output is held by the override, its event-driven state keeps updating. When the override is released, the output shows that live state at once.
- R8: A compare value of 0 with normal-polarity actions gives a continuously low output.
- R9: In a cycle with no strobe and no write, both outputs hold their level. A write to address 3 changes nothing.
- R10: Channel A uses the register at address 0 and channel B the register at address 1. Configuring, driving or holding one channel does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_zero_i | input | 1 | Counter-equals-zero strobe |
| evt_cmpa_i | input | 1 | Counter-equals-compare-A strobe while counting up |
| evt_cmpb_i | input | 1 | Counter-equals-compare-B strobe while counting up |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register address: 0 action A, 1 action B, 2 override |
| wr_data_i | input | 16 | Register write data |
| pwm_a_o | output | 1 | Channel A output level |
| pwm_b_o | output | 1 | Channel B output level |

## Verification
A bench counter model runs full periods in three configurations. Normal polarity with a mid-range compare value shows that the output is high for exactly the compare value in ticks. Inverted polarity shows the complementary count. A compare value of zero shows that the compare action wins over the coincident zero action. Single-cycle strobe combinations separate the three-way priority from the rule that "no action" does not mask a lower-priority event, and a toggle-only setting shows that the state is held between events. Override sequences interleaved with events show that a held pin hides a state that keeps changing. Writes to the unused address, and idle cycles, show that nothing moves without a cause.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'd0,
    FRC_LOW  = 2'd1,
    FRC_HIGH = 2'd2,
    FRC_RSVD = 2'd3
  } frc_e;

  localparam int unsigned ACT_W    = 10;
  localparam int unsigned ZERO_LSB = 0;
  localparam int unsigned CMPA_LSB = 4;
  localparam int unsigned CMPB_LSB = 8;
endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import aq_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 2,
  parameter int unsigned DW  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [NCH*ACT_W-1:0] act_o,
  output logic [2*NCH-1:0]     frc_o
);
  localparam logic [AW-1:0] FRC_ADDR = AW'(NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_act
    localparam logic [AW-1:0] MY_ADDR = AW'(c);
    logic [ACT_W-1:0] act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= '0;
      else if (wr_en_i && wr_addr_i == MY_ADDR) act_q <= wr_data_i[ACT_W-1:0];
    end
    assign act_o[c*ACT_W +: ACT_W] = act_q;
  end

  logic [2*NCH-1:0] frc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frc_q <= '0;
    else if (wr_en_i && wr_addr_i == FRC_ADDR) frc_q <= wr_data_i[2*NCH-1:0];
  end
  assign frc_o = frc_q;
endmodule

// File: rtl/aq_chan.sv
module aq_chan
  import aq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACT_W-1:0] act_i,
  input  logic             evt_zero_i,
  input  logic             evt_cmpa_i,
  input  logic             evt_cmpb_i,
  input  logic [1:0]       frc_i,
  output logic             pin_o
);
  act_e a_zero, a_cmpa, a_cmpb, a_sel;
  logic st_q, st_d;

  assign a_zero = act_e'(act_i[ZERO_LSB +: 2]);
  assign a_cmpa = act_e'(act_i[CMPA_LSB +: 2]);
  assign a_cmpb = act_e'(act_i[CMPB_LSB +: 2]);

  // highest-priority strobed event with a real action wins
  always_comb begin
    a_sel = ACT_NONE;
    if (evt_zero_i && a_zero != ACT_NONE) a_sel = a_zero;
    if (evt_cmpa_i && a_cmpa != ACT_NONE) a_sel = a_cmpa;
    if (evt_cmpb_i && a_cmpb != ACT_NONE) a_sel = a_cmpb;
  end

  always_comb begin
    unique case (a_sel)
      ACT_LOW:    st_d = 1'b0;
      ACT_HIGH:   st_d = 1'b1;
      ACT_TOGGLE: st_d = ~st_q;
      default:    st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= st_d;
  end

  always_comb begin
    unique case (frc_e'(frc_i))
      FRC_LOW:  pin_o = 1'b0;
      FRC_HIGH: pin_o = 1'b1;
      default:  pin_o = st_q;
    endcase
  end
endmodule

// File: rtl/aq_action_qual.sv
module aq_action_qual
  import aq_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_zero_i,
  input  logic          evt_cmpa_i,
  input  logic          evt_cmpb_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          pwm_a_o,
  output logic          pwm_b_o
);
  localparam int unsigned NCH = 2;

  logic [NCH*ACT_W-1:0] act_w;
  logic [2*NCH-1:0]     frc_w;
  logic [NCH-1:0]       pin_w;

  aq_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .act_o     (act_w),
    .frc_o     (frc_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    aq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_w[c*ACT_W +: ACT_W]),
      .evt_zero_i (evt_zero_i),
      .evt_cmpa_i (evt_cmpa_i),
      .evt_cmpb_i (evt_cmpb_i),
      .frc_i      (frc_w[2*c +: 2]),
      .pin_o      (pin_w[c])
    );
  end

  assign pwm_a_o = pin_w[0];
  assign pwm_b_o = pin_w[1];
endmodule

// File: rtl/aq_checker.sv
module aq_checker #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          evt_zero_i,
  input logic          evt_cmpa_i,
  input logic          evt_cmpb_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [19:0]   act_i,
  input logic [3:0]    frc_i,
  input logic          pwm_a_o,
  input logic          pwm_b_o
);
  logic no_evt;
  assign no_evt = !evt_zero_i && !evt_cmpa_i && !evt_cmpb_i;

  // R5: holding channel A low/high shows after the write edge
  a_r5_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(2) && wr_data_i[1:0] == 2'd1) |=> !pwm_a_o);
  a_r5_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(2) && wr_data_i[1:0] == 2'd2) |=> pwm_a_o);

  // R3: zero event with drive-high action sets the output next edge
  a_r3_zero_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_zero_i && !evt_cmpa_i && !evt_cmpb_i && frc_i[1:0] == 2'd0
     && act_i[1:0] == 2'd2) |=> pwm_a_o);

  // R6: compare A clear beats a coincident zero set
  a_r6_cmp_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_zero_i && evt_cmpa_i && !evt_cmpb_i && frc_i[1:0] == 2'd0
     && act_i[1:0] == 2'd2 && act_i[5:4] == 2'd1) |=> !pwm_a_o);

  // R9: nothing moves without a strobe or a write
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && no_evt) |=> ($stable(pwm_a_o) && $stable(pwm_b_o)));
endmodule

bind aq_action_qual aq_checker #(.AW(AW), .DW(DW)) u_aq_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_zero_i (evt_zero_i),
  .evt_cmpa_i (evt_cmpa_i),
  .evt_cmpb_i (evt_cmpb_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .act_i      (act_w),
  .frc_i      (frc_w),
  .pwm_a_o    (pwm_a_o),
  .pwm_b_o    (pwm_b_o)
);

// File: tb/tb_aq_action_qual.sv
module tb_aq_action_qual;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ez = 1'b0, ea = 1'b0, eb = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  wa = '0;
  logic [15:0] wd = '0;
  logic        pa, pb;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aq_action_qual dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_zero_i(ez), .evt_cmpa_i(ea), .evt_cmpb_i(eb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .pwm_a_o(pa), .pwm_b_o(pb)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    we = 1'b1; wa = a; wd = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wa = '0; wd = '0;
  endtask

  task automatic tick(logic z, logic a, logic b);
    ez = z; ea = a; eb = b;
    @(posedge clk); @(negedge clk);
    ez = 1'b0; ea = 1'b0; eb = 1'b0;
  endtask

  // one counter period; counts ticks with each output high
  task automatic period(int p, int ca, int cb, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int c = 0; c < p; c++) begin
      tick(c == 0, c == ca, c == cb);
      ha += int'(pa); hb += int'(pb);
    end
  endtask

  task automatic t_reset;
    check("R1 reset A", pa, 0);
    check("R1 reset B", pb, 0);
    tick(1, 1, 1);
    check("R1 no action A", pa, 0);
    check("R1 no action B", pb, 0);
  endtask

  task automatic t_normal;
    int ha, hb;
    wr(2'd0, 16'h012);   // A: zero high, cmpA low
    wr(2'd1, 16'h102);   // B: zero high, cmpB low
    period(8, 3, 5, ha, hb);
    period(8, 3, 5, ha, hb);
    check("R4 normal high ticks A", ha, 3);
    check("R10 normal high ticks B", hb, 5);
  endtask

  task automatic t_inverted;
    int ha, hb;
    wr(2'd0, 16'h021);   // R2: zero low (bits 1:0), cmpA high (bits 5:4)
    period(8, 3, 5, ha, hb);
    period(8, 3, 5, ha, hb);
    check("R4 inverted high ticks A", ha, 5);
    check("R10 B unaffected", hb, 5);
  endtask

  task automatic t_cmp_zero;
    int ha, hb;
    wr(2'd0, 16'h012);
    period(6, 0, 2, ha, hb);
    period(6, 0, 2, ha, hb);
    check("R8 compare zero low", ha, 0);
    check("R8 B still runs", hb, 2);
  endtask

  task automatic t_toggle;
    wr(2'd0, 16'h003);
    tick(0, 0, 0);
    check("R9 idle hold", pa, 0);
    tick(1, 0, 0);
    check("R2 toggle up", pa, 1);
    tick(0, 1, 1);
    check("R2 cmp none ignored", pa, 1);
    tick(1, 0, 0);
    check("R2 toggle down", pa, 0);
  endtask

  task automatic t_priority;
    wr(2'd0, 16'h212);   // zero high, cmpA low, cmpB high
    tick(1, 1, 1);
    check("R6 B over A", pa, 1);
    tick(1, 1, 0);
    check("R6 A over zero", pa, 0);
    tick(0, 1, 1);
    check("R6 B over A no zero", pa, 1);
    wr(2'd0, 16'h012);   // cmpB none
    tick(1, 1, 1);
    check("R6 none does not mask", pa, 0);
    wr(2'd0, 16'h210);   // zero none, cmpA low, cmpB high
    tick(1, 0, 0);
    check("R6 zero none holds", pa, 0);
  endtask

  task automatic t_force;
    wr(2'd0, 16'h012);
    wr(2'd1, 16'h102);
    tick(1, 0, 0);
    check("R5 live before force", pa, 1);
    wr(2'd2, 16'h0001);
    check("R5 force low A", pa, 0);
    check("R10 B not forced", pb, 1);
    tick(0, 0, 1);
    check("R10 B live under A force", pb, 0);
    tick(0, 1, 0);
    tick(1, 0, 0);
    check("R7 held while state high", pa, 0);
    wr(2'd2, 16'h0000);
    check("R7 release to live high", pa, 1);
    wr(2'd2, 16'h0002);
    tick(0, 1, 0);
    check("R5 force high A", pa, 1);
    wr(2'd2, 16'h0003);
    check("R5 code 3 releases", pa, 0);
    wr(2'd2, 16'h0008);
    check("R5 force high B", pb, 1);
    check("R10 A not forced by B", pa, 0);
    wr(2'd2, 16'h0004);
    check("R5 force low B", pb, 0);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_ignore;
    wr(2'd0, 16'h012);
    tick(1, 0, 0);
    wr(2'd3, 16'hFFFF);
    check("R9 addr3 A", pa, 1);
    check("R9 addr3 B", pb, 1);
    tick(0, 1, 0);
    check("R9 config kept A", pa, 0);
    tick(1, 0, 0);
    check("R9 config kept zero", pa, 1);
    tick(0, 0, 0);
    tick(0, 0, 0);
    check("R9 idle A", pa, 1);
    check("R9 idle B", pb, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_inverted();
    t_cmp_zero();
    t_toggle();
    t_priority();
    t_force();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule